// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the command side of a two-wire serial EEPROM with 256 byte locations. It samples the raw clock and data lines on a fast system clock and finds the bus start and stop conditions. It shifts bytes in and out most significant bit first, and it pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero. The first byte after a start is a select byte. The block answers it only when the device-type nibble is one it recognises and the three chip-address bits match its strap pins.

The block keeps an 8-bit address pointer and supports five transfers: single-byte writes, page writes, reads at the current pointer, random reads (an address-only write header followed by a repeated start) and sequential reads. Each accepted write byte goes out as a staging strobe to an external page-write engine. A stop placed in the slot that follows a data acknowledge tells the engine to commit. While the engine reports busy, the block stays off the bus completely, so a master can poll for the end of the write cycle by watching the acknowledge. Read bytes come from a synchronous memory port that has one cycle of latency.

A second device-type code controls a one-way lock over the lower half of the array. A hardware lock input blocks writes to the whole array.

Top module: `sp_eeprom_ctrl`

## Requirements
- R1: A select byte is acknowledged only if its bits 3..1 equal `chip_sel` and its bits 7..4 are 1010 (array, either direction) or 0110 (lock, write direction only, while the lock is clear and `wr_lock` is low). Bit 0 set to 1 means read. Any other select byte gets no acknowledge, and the block ignores the bus until the next start.
- R2: An acknowledge is driven (`sda_oe` high) from the clock-low phase after the eighth bit until the next clock fall. The block starts driving the line only while the synchronised clock is low.
- R3: In a write, the byte after the select byte loads the pointer. Each acknowledged data byte raises `buf_we` for one cycle with the pointer on `buf_addr` and the byte on `buf_data`. The low 4 pointer bits then advance and wrap inside the 16-byte page.
- R4: `commit` pulses once only for a stop given in the clock period right after a data-byte acknowledge, and only if at least one data byte of the transfer was accepted. A stop at any other point commits nothing.
- R5: While `wr_lock` is high, every array data byte gets no acknowledge and produces no `buf_we`.
- R6: A lock-code write (select, address, data, then a stop in the slot after the data acknowledge) permanently write-protects addresses 00h..7Fh. Data bytes to those addresses then get no acknowledge and are not staged, and the lock code is no longer acknowledged. The lock code is never acknowledged with bit 0 set to 1.
- R7: A read at the current pointer returns the byte at the pointer, most significant bit first (a 0 bit drives `sda_oe` high), and the pointer then advances by one.
- R8: A write header with an address, followed by a repeated start and a read select, returns the byte at that address.
- R9: While the master acknowledges read bytes, the next byte follows, and the pointer wraps from FFh to 00h.
- R10: A read byte that the master does not acknowledge ends the transfer. The line stays released, and the pointer is left one past the last byte sent.
- R11: While `eng_busy` is high, `sda_oe` stays low and no select byte is acknowledged, including a matching one.
- R12: After reset, `sda_oe`, `buf_we`, `commit` and `mem_rd_en` are low, the pointer is 00h and the lower-half lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired level) |
| sda_oe | output | 1 | High pulls the data line low |
| chip_sel | input | 3 | Strap value matched against select bits 3..1 |
| wr_lock | input | 1 | High blocks all array writes |
| eng_busy | input | 1 | Page-write engine is programming |
| buf_we | output | 1 | Stage one byte in the page engine |
| buf_addr | output | ADDR_W | Address of the staged byte |
| buf_data | output | 8 | Staged byte |
| commit | output | 1 | Start the programming cycle |
| mem_rd_en | output | 1 | Read request to the array |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |

## Verification
The bound checker watches, on every cycle, the properties that hold regardless of the transfer in progress: the line stays released while the engine is busy, the line is never first pulled low during clock high, no byte is staged under the hardware lock or below 80h once the lower half is locked, the lock never clears, and a commit never overlaps a drive or a staging strobe. Only the bench's transfers can show the values that come back: page wrap, pointer advance after current, random and sequential reads, the FFh to 00h wrap, the stop slot that decides a commit, refused selects, and the lock sequence with its effect on later writes.

// File: rtl/sp_eeprom_pkg.sv
package sp_eeprom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_LOCK  = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } phase_e;

    typedef enum logic [1:0] {
        K_SEL,
        K_ADDR,
        K_DATA
    } kind_e;

    typedef struct packed {
        logic [3:0] dtype;
        logic [2:0] ce;
        logic       rnw;
    } sel_t;

    // A data byte is refused under the hardware lock, or when the lower half
    // is locked and the target lies in it.
    function automatic logic write_blocked(input logic hi_half,
                                           input logic lock,
                                           input logic low_locked);
        return lock | (low_locked & ~hi_half);
    endfunction

endpackage

// File: rtl/sp_bus_sync.sv
module sp_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_raw};
            sda_p <= {sda_p[STAGES-2:0], sda_raw};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s    = scl_p[STAGES-1];
    assign sda_s    = sda_p[STAGES-1];
    assign ev_rise  = scl_s & ~scl_d;
    assign ev_fall  = ~scl_s & scl_d;
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/sp_byte_shift.sv
module sp_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_en,
    input  logic         rx_bit,
    input  logic         tx_load,
    input  logic [W-1:0] tx_val,
    input  logic         tx_en,
    output logic [W-1:0] rx_byte,
    output logic [W-1:0] tx_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            tx_byte <= '0;
        end else begin
            if (rx_en)
                rx_byte <= {rx_byte[W-2:0], rx_bit};
            if (tx_load)
                tx_byte <= tx_val;
            else if (tx_en)
                tx_byte <= {tx_byte[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/sp_eeprom_ctrl.sv
module sp_eeprom_ctrl
    import sp_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        chip_sel,
    input  logic              wr_lock,
    input  logic              eng_busy,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_data,
    output logic              commit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data
);
    localparam logic [3:0] LAST_RX = 4'(BYTE_W);
    localparam logic [3:0] LAST_TX = 4'(BYTE_W - 1);

    logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;
    logic [BYTE_W-1:0] rx_byte, tx_byte;

    phase_e            st;
    kind_e             kind;
    logic [3:0]        cnt;
    logic [ADDR_W-1:0] addr_ctr;
    logic [ADDR_W-1:0] page_next;
    logic              is_read, tgt_lock, data_acked, prot_set, rd_pend;

    sp_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .ev_start(ev_start), .ev_stop(ev_stop)
    );

    logic active, rx_en, tx_en;
    assign active = ~eng_busy & ~ev_start & ~ev_stop;
    assign rx_en  = active && st == ST_RX && ev_rise && cnt < LAST_RX;
    assign tx_en  = active && st == ST_TX && ev_fall && cnt != LAST_TX;

    sp_byte_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(sda_s),
        .tx_load(rd_pend), .tx_val(mem_rd_data), .tx_en(tx_en),
        .rx_byte(rx_byte), .tx_byte(tx_byte)
    );

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign page_next = addr_ctr + 1'b1;
        end else begin : g_paged
            assign page_next = {addr_ctr[ADDR_W-1:PAGE_W], addr_ctr[PAGE_W-1:0] + 1'b1};
        end
    endgenerate

    sel_t sel;
    logic sel_hit, data_ok;
    always_comb begin
        sel     = sel_t'(rx_byte);
        sel_hit = (sel.ce == chip_sel) &&
                  ((sel.dtype == TYPE_ARRAY) ||
                   (sel.dtype == TYPE_LOCK && !sel.rnw && !prot_set && !wr_lock));
        data_ok = tgt_lock || !write_blocked(addr_ctr[ADDR_W-1], wr_lock, prot_set);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            kind        <= K_SEL;
            cnt         <= '0;
            addr_ctr    <= '0;
            is_read     <= 1'b0;
            tgt_lock    <= 1'b0;
            data_acked  <= 1'b0;
            prot_set    <= 1'b0;
            rd_pend     <= 1'b0;
            sda_oe      <= 1'b0;
            buf_we      <= 1'b0;
            buf_addr    <= '0;
            buf_data    <= '0;
            commit      <= 1'b0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            buf_we    <= 1'b0;
            commit    <= 1'b0;
            mem_rd_en <= 1'b0;
            rd_pend   <= mem_rd_en;
            if (eng_busy) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev_start) begin
                st         <= ST_RX;
                kind       <= K_SEL;
                cnt        <= '0;
                sda_oe     <= 1'b0;
                data_acked <= 1'b0;
            end else if (ev_stop) begin
                // the stop's own clock rise shifted one bit: slot after an ack
                if (st == ST_RX && kind == K_DATA && cnt == 4'd1 && data_acked) begin
                    if (tgt_lock) prot_set <= 1'b1;
                    else          commit   <= 1'b1;
                end
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (rx_en) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev_fall && cnt == LAST_RX) begin
                            case (kind)
                                K_SEL: begin
                                    if (sel_hit) begin
                                        st       <= ST_RXACK;
                                        sda_oe   <= 1'b1;
                                        is_read  <= sel.rnw;
                                        tgt_lock <= (sel.dtype == TYPE_LOCK);
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                K_ADDR: begin
                                    st     <= ST_RXACK;
                                    sda_oe <= 1'b1;
                                    if (!tgt_lock) addr_ctr <= rx_byte[ADDR_W-1:0];
                                end
                                default: begin
                                    st     <= ST_RXACK;
                                    sda_oe <= data_ok;
                                    if (data_ok) begin
                                        data_acked <= 1'b1;
                                        if (!tgt_lock) begin
                                            buf_we   <= 1'b1;
                                            buf_addr <= addr_ctr;
                                            buf_data <= rx_byte;
                                            addr_ctr <= page_next;
                                        end
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (ev_rise && kind == K_SEL && is_read) begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= addr_ctr;
                            addr_ctr    <= addr_ctr + 1'b1;
                        end else if (ev_fall) begin
                            cnt <= '0;
                            if (kind == K_SEL && is_read) begin
                                st     <= ST_TX;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                            end else begin
                                st     <= ST_RX;
                                sda_oe <= 1'b0;
                                kind   <= (kind == K_SEL) ? K_ADDR : K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_fall) begin
                            if (cnt == LAST_TX) begin
                                st     <= ST_TXACK;
                                sda_oe <= 1'b0;
                            end else begin
                                cnt    <= cnt + 4'd1;
                                sda_oe <= ~tx_byte[BYTE_W-2];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (ev_rise) begin
                            if (!sda_s) begin
                                mem_rd_en   <= 1'b1;
                                mem_rd_addr <= addr_ctr;
                                addr_ctr    <= addr_ctr + 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (ev_fall) begin
                            st     <= ST_TX;
                            cnt    <= '0;
                            sda_oe <= ~tx_byte[BYTE_W-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sp_eeprom_ctrl_chk.sv
module sp_eeprom_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              eng_busy,
    input logic              wr_lock,
    input logic              prot_set,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              commit
);
    // R11
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && $past(eng_busy)) |-> !sda_oe);

    // R2
    drive_in_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R5
    lock_blocks_stage_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> !$past(wr_lock));

    // R6
    low_half_guard_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (buf_addr[ADDR_W-1] || !$past(prot_set)));

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(prot_set));

    // R4
    commit_alone_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (!sda_oe && !buf_we));

endmodule

bind sp_eeprom_ctrl sp_eeprom_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s),
    .eng_busy(eng_busy), .wr_lock(wr_lock), .prot_set(prot_set),
    .buf_we(buf_we), .buf_addr(buf_addr), .commit(commit)
);

// File: tb/sp_eeprom_ctrl_bench.sv
module sp_eeprom_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int BUSY_CYC   = 300;
    localparam int WDOG       = 150000;
    localparam logic [2:0] CS = 3'b101;
    localparam logic [7:0] SEL_W  = 8'hAA;  // 1010 101 0
    localparam logic [7:0] SEL_R  = 8'hAB;
    localparam logic [7:0] LOCK_W = 8'h6A;  // 0110 101 0
    localparam logic [7:0] LOCK_R = 8'h6B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_oe, buf_we, commit, mem_rd_en, eng_busy;
    logic [7:0] buf_addr, buf_data, mem_rd_addr, mem_rd_data;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    sp_eeprom_ctrl u_sp_eeprom_ctrl (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .chip_sel(CS), .wr_lock(wr_lock), .eng_busy(eng_busy),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .commit(commit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    // array, staging buffer and programming engine models
    logic [7:0]   mem [256];
    logic [7:0]   pend_d [256];
    logic [255:0] pend_v;
    int           busy_cnt;
    int           n_commit;
    assign eng_busy = (busy_cnt != 0);

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        pend_v   = '0;
        busy_cnt = 0;
        n_commit = 0;
        mem_rd_data = 8'h00;
    end

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (buf_we) begin
            pend_d[buf_addr] <= buf_data;
            pend_v[buf_addr] <= 1'b1;
        end
        if (commit) begin
            for (int i = 0; i < 256; i++) if (pend_v[i]) mem[i] <= pend_d[i];
            pend_v   <= '0;
            busy_cnt <= BUSY_CYC;
            n_commit <= n_commit + 1;
        end
    end

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        cyc(2); sda_m = b; cyc(Q-2);
        scl_m = 1'b1; cyc(Q);
        scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        cyc(2); sda_m = 1'b1; cyc(Q-2);
        scl_m = 1'b1; cyc(Q/2);
        b = sda_line; cyc(Q/2);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        cyc(2); sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        cyc(2); sda_m = 1'b0; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~mack);
    endtask

    task automatic wait_idle();
        cyc(4);
        while (eng_busy) cyc(1);
        cyc(4);
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d,
                              output logic hdr_ok, output logic dack);
        logic a1, a2;
        bus_start();
        wr_byte(SEL_W, a1);
        wr_byte(a, a2);
        wr_byte(d, dack);
        bus_stop();
        hdr_ok = a1 & a2;
        wait_idle();
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start();
        wr_byte(SEL_W, a1);
        wr_byte(a, a2);
        bus_start();
        wr_byte(SEL_R, a3);
        rd_byte(1'b0, d);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    typedef struct packed {
        logic       is_wr;
        logic [7:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'h10, 8'h3C},
        '{1'b1, 8'h80, 8'hC3},
        '{1'b1, 8'hFF, 8'h96},
        '{1'b0, 8'h10, 8'h3C},
        '{1'b0, 8'h80, 8'hC3},
        '{1'b0, 8'hFF, 8'h96},
        '{1'b0, 8'h42, 8'hE7},
        '{1'b0, 8'h20, 8'h85}
    };

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R1..: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic ok, ack, b;
        logic [7:0] d, d1, d2;
        int c0;

        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R12 reset state
        chk("R12 sda_oe after reset", 32'(sda_oe), 32'd0);
        chk("R12 strobes after reset", {29'd0, buf_we, commit, mem_rd_en}, 32'd0);
        cyc(10);

        // vector table: R3 single writes, R8 random reads
        foreach (VECS[i]) begin
            if (VECS[i].is_wr) begin
                byte_write(VECS[i].addr, VECS[i].data, ok, ack);
                chk("R3 write header ack", 32'(ok), 32'd1);
                chk("R3 write data ack", 32'(ack), 32'd1);
            end else begin
                rand_read(VECS[i].addr, d, ok);
                chk("R8 random read acks", 32'(ok), 32'd1);
                chk("R8 random read data", 32'(d), 32'(VECS[i].data));
            end
        end

        // R1 select mismatch: wrong chip bits, wrong type, then no start
        bus_start();
        wr_byte(8'hA8, ack);
        chk("R1 wrong chip bits refused", 32'(ack), 32'd0);
        wr_byte(SEL_W, ack);
        chk("R1 ignored until next start", 32'(ack), 32'd0);
        bus_stop();
        bus_start();
        wr_byte(8'hBA, ack);
        chk("R1 unknown type refused", 32'(ack), 32'd0);
        bus_stop();
        bus_start();
        wr_byte(SEL_W, ack);
        chk("R2 matching select acknowledged", 32'(ack), 32'd1);
        bus_stop();

        // R3 page write wrapping inside the 16-byte page
        bus_start();
        wr_byte(SEL_W, ok);
        wr_byte(8'h1E, ok);
        wr_byte(8'h11, ok);
        wr_byte(8'h22, ok);
        wr_byte(8'h33, ack);
        bus_stop();
        chk("R3 page data ack", 32'(ack), 32'd1);
        wait_idle();
        rand_read(8'h1E, d, ok);
        chk("R3 page byte 0", 32'(d), 32'h11);
        // R7 current read continues at pointer
        bus_start();
        wr_byte(SEL_R, ack);
        rd_byte(1'b0, d);
        bus_stop();
        chk("R7 current read after random", 32'(d), 32'h22);
        rand_read(8'h10, d, ok);
        chk("R3 page wrap to 10h", 32'(d), 32'h33);
        rand_read(8'h20, d, ok);
        chk("R3 next page untouched", 32'(d), 32'h85);

        // R4 stop inside a data byte commits nothing
        c0 = n_commit;
        bus_start();
        wr_byte(SEL_W, ok);
        wr_byte(8'h30, ok);
        wr_byte(8'h12, ok);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        bus_stop();
        cyc(20);
        chk("R4 mid-byte stop no commit", 32'(n_commit - c0), 32'd0);
        rand_read(8'h30, d, ok);
        chk("R4 location unchanged", 32'(d), 32'h95);

        // R11 busy engine: matching select refused
        bus_start();
        wr_byte(SEL_W, ok);
        wr_byte(8'h31, ok);
        wr_byte(8'h5A, ok);
        bus_stop();
        chk("R4 commit on tenth slot", 32'(n_commit - c0), 32'd1);
        bus_start();
        wr_byte(SEL_W, ack);
        bus_stop();
        chk("R11 no ack while busy", 32'(ack), 32'd0);
        wait_idle();
        rand_read(8'h31, d, ok);
        chk("R11 ack after busy ends", 32'(ok), 32'd1);
        chk("R11 written byte read back", 32'(d), 32'h5A);

        // R9 sequential read across FFh
        bus_start();
        wr_byte(SEL_W, ok);
        wr_byte(8'hFE, ok);
        bus_start();
        wr_byte(SEL_R, ok);
        rd_byte(1'b1, d);
        rd_byte(1'b1, d1);
        rd_byte(1'b0, d2);
        chk("R9 seq byte FEh", 32'(d), 32'h5B);
        chk("R9 seq byte FFh", 32'(d1), 32'h96);
        chk("R9 seq wrap 00h", 32'(d2), 32'hA5);
        // R10 released after master NoAck
        bit_in(b);
        chk("R10 line released after NoAck", 32'(b), 32'd1);
        bus_stop();
        bus_start();
        wr_byte(SEL_R, ok);
        rd_byte(1'b0, d);
        bus_stop();
        chk("R10 pointer one past last", 32'(d), 32'hA4);

        // R5 hardware lock
        wr_lock = 1'b1;
        c0 = n_commit;
        byte_write(8'h50, 8'h77, ok, ack);
        chk("R5 data NoAck under lock", 32'(ack), 32'd0);
        chk("R5 no commit under lock", 32'(n_commit - c0), 32'd0);
        wr_lock = 1'b0;
        rand_read(8'h50, d, ok);
        chk("R5 location unchanged", 32'(d), 32'hF5);

        // R6 lower-half lock
        bus_start();
        wr_byte(LOCK_R, ack);
        bus_stop();
        chk("R6 lock code read refused", 32'(ack), 32'd0);
        bus_start();
        wr_byte(LOCK_W, ok);
        chk("R6 lock code accepted", 32'(ok), 32'd1);
        wr_byte(8'h00, ok);
        wr_byte(8'h00, ack);
        bus_stop();
        chk("R6 lock data ack", 32'(ack), 32'd1);
        cyc(20);
        byte_write(8'h05, 8'h99, ok, ack);
        chk("R6 low half NoAck", 32'(ack), 32'd0);
        rand_read(8'h05, d, ok);
        chk("R6 low half unchanged", 32'(d), 32'hA0);
        byte_write(8'h85, 8'h99, ok, ack);
        chk("R6 upper half ack", 32'(ack), 32'd1);
        rand_read(8'h85, d, ok);
        chk("R6 upper half written", 32'(d), 32'h99);
        bus_start();
        wr_byte(LOCK_W, ack);
        bus_stop();
        chk("R6 lock code gone after set", 32'(ack), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule